// File: doc/BRIEF.md
# IR Physical-Layer Mode Configuration Gate

This block sits between a register port and the modulators of an infrared physical layer. Software stages two words while the PHY enable bit is low. The first is a mode word that picks the encoding family, the CRC width and the transmit, receive and loopback controls. The second is a next-PHY word holding the baud divisor, the pulse width and the preamble length. On the write that moves the enable bit from 0 to 1, the staged encoding selection and the whole next-PHY word are copied into the applied registers in one clock edge. The datapath therefore never sees a half-updated setting.

The enable/status register reports what was actually applied: which encoding is running, whether 16-bit CRC is active, and a configuration-error flag for a committed word that names more than one encoding. It also reports the transmit and receive enable status, which follow the live mode word. Clearing the enable bit stops the datapath straight away, and the last applied PHY word can still be read back.

Top module: `ir_cfg_gate`

## Requirements
- R1: After synchronous reset every register reads 0, all status bits are 0 and the datapath mode code is idle (0).
- R2: Register map on the 2-bit address: 0 = mode word, 1 = enable/status, 2 = next-PHY word, 3 = applied-PHY word. Addresses 0 and 2 read back the full 16-bit value last written. Writes to address 3 are ignored.
- R3: The applied-PHY word takes the next-PHY value only on a write to address 1 with bit 15 set while the enable bit is 0. At all other times it holds: during later writes to address 2 while enabled, and during a repeated enable write while already enabled.
- R4: The encoding selections in the mode word (SIR bit 4, MIR bit 5, FIR bit 6) and 16-bit CRC (bit 7) take effect only at that commit. Changing them while enabled leaves the status and datapath outputs unchanged.
- R5: Enable/status bit 14 (configuration error) reads 1 while enabled if the committed word has more than one of bits 4, 5 and 6 set.
- R6: While enabled and error-free, status bits 13 (FIR on), 12 (MIR on), 11 (SIR on) and 8 (16-bit CRC on) equal the committed bits 6, 5, 4 and 7. Under an error, bits 13, 12, 11 and 8 read 0.
- R7: Status bit 10 equals the live mode-word transmit enable (bit 12). Status bit 9 equals the live receive enable (bit 11) AND (NOT bit 12 OR loopback bit 14).
- R8: The enable/status register reads its written enable bit at bit 15. Bits 7:0 always read 0, whatever was written there.
- R9: Writing bit 15 = 0 to address 1 clears bits 14, 13, 12, 11 and 8 on the next cycle and puts the datapath in idle. The applied-PHY word stays readable and unchanged.
- R10: Datapath outputs give the applied baud field (bits 15:10), pulse-width field (bits 9:5) and preamble field (bits 4:0). The mode code is 1 = SIR, 2 = MIR, 3 = FIR, and 0 when disabled or in error. The CRC16 output equals status bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for reg_addr |
| mode_o | output | 2 | Applied encoding: 0 idle, 1 SIR, 2 MIR, 3 FIR |
| crc16_o | output | 1 | 16-bit CRC selected for the running mode |
| baud_o | output | 6 | Applied baud divisor field |
| pulse_w_o | output | 5 | Applied pulse-width field |
| preamble_o | output | 5 | Applied preamble length field |
| tx_on_o | output | 1 | Transmit enable status |
| rx_on_o | output | 1 | Receive enable status |

## Verification
The assertions assume that the register port carries at most one write per cycle and that the enable bit changes only through writes to address 1. Under that assumption, a rise of the stored enable bit marks a commit, and the applied-PHY word must otherwise be stable. The stimulus drives one write per call and keeps the strobe low between writes, so no two writes overlap. It sweeps all sixteen encoding/CRC selections against all eight transmit/receive/loopback combinations. In each case it stages a second, different configuration while enabled, and it repeats the enable write, so that a stray commit would show up at the ports.

// File: rtl/ircfg_pkg.sv
package ircfg_pkg;

    localparam int REG_W   = 16;
    localparam int BAUD_W  = 6;
    localparam int PLS_W   = 5;
    localparam int PRE_W   = 5;
    localparam int PHY_W   = BAUD_W + PLS_W + PRE_W;
    localparam int MODE_W  = 2;

    // register map
    localparam int ADR_CFG  = 0;
    localparam int ADR_EN   = 1;
    localparam int ADR_NPHY = 2;
    localparam int ADR_APHY = 3;

    // mode word bit positions
    localparam int CB_SIR   = 4;
    localparam int CB_MIR   = 5;
    localparam int CB_FIR   = 6;
    localparam int CB_CRC   = 7;
    localparam int CB_ENRX  = 11;
    localparam int CB_ENTX  = 12;
    localparam int CB_LOOP  = 14;

    // enable/status bit positions
    localparam int SB_EN    = 15;
    localparam int SB_ERR   = 14;
    localparam int SB_FIR   = 13;
    localparam int SB_MIR   = 12;
    localparam int SB_SIR   = 11;
    localparam int SB_TX    = 10;
    localparam int SB_RX    = 9;
    localparam int SB_CRC   = 8;

    typedef enum logic [MODE_W-1:0] {
        MODE_IDLE = 2'd0,
        MODE_SIR  = 2'd1,
        MODE_MIR  = 2'd2,
        MODE_FIR  = 2'd3
    } ir_mode_e;

    typedef struct packed {
        logic [BAUD_W-1:0] baud;
        logic [PLS_W-1:0]  pls;
        logic [PRE_W-1:0]  pre;
    } phy_word_t;

    typedef struct packed {
        logic crc16;
        logic fir;
        logic mir;
        logic sir;
    } enc_sel_t;

    typedef struct packed {
        logic err;
        logic fir_on;
        logic mir_on;
        logic sir_on;
        logic tx_st;
        logic rx_st;
        logic crc_on;
    } status_t;

    function automatic enc_sel_t cfg_to_sel(input logic [REG_W-1:0] w);
        enc_sel_t s;
        s.crc16 = w[CB_CRC];
        s.fir   = w[CB_FIR];
        s.mir   = w[CB_MIR];
        s.sir   = w[CB_SIR];
        return s;
    endfunction

    function automatic logic sel_conflict(input enc_sel_t s);
        return (s.sir & s.mir) | (s.sir & s.fir) | (s.mir & s.fir);
    endfunction

    function automatic logic [REG_W-1:0] status_word(input logic en, input status_t st);
        logic [REG_W-1:0] w;
        w = '0;
        w[SB_EN]  = en;
        w[SB_ERR] = st.err;
        w[SB_FIR] = st.fir_on;
        w[SB_MIR] = st.mir_on;
        w[SB_SIR] = st.sir_on;
        w[SB_TX]  = st.tx_st;
        w[SB_RX]  = st.rx_st;
        w[SB_CRC] = st.crc_on;
        return w;
    endfunction

endpackage

// File: rtl/ircfg_stage.sv
module ircfg_stage
    import ircfg_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [REG_W-1:0]     wdata,
    output logic [REG_W-1:0]     cfg_q,
    output phy_word_t            nphy_q,
    output logic                 en_q,
    output logic                 commit
);

    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(ADR_CFG);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(ADR_EN);
    localparam logic [ADDR_W-1:0] A_NPHY = ADDR_W'(ADR_NPHY);

    logic wr_cfg, wr_en_reg, wr_nphy;

    always_comb begin
        wr_cfg    = wr_en && (addr == A_CFG);
        wr_en_reg = wr_en && (addr == A_EN);
        wr_nphy   = wr_en && (addr == A_NPHY);
        commit    = wr_en_reg && wdata[SB_EN] && !en_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            nphy_q <= '0;
            en_q   <= 1'b0;
        end else begin
            if (wr_cfg)    cfg_q  <= wdata;
            if (wr_nphy)   nphy_q <= phy_word_t'(wdata);
            if (wr_en_reg) en_q   <= wdata[SB_EN];
        end
    end

    // R9
    en_follows_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en_reg |=> (en_q == $past(wdata[SB_EN])));

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_cfg |=> $stable(cfg_q));

endmodule

// File: rtl/ircfg_commit.sv
module ircfg_commit
    import ircfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             commit,
    input  logic [REG_W-1:0] cfg_q,
    input  phy_word_t        nphy_q,
    output enc_sel_t         app_sel,
    output phy_word_t        app_phy
);

    always_ff @(posedge clk) begin
        if (rst) begin
            app_sel <= '0;
            app_phy <= '0;
        end else if (commit) begin
            app_sel <= cfg_to_sel(cfg_q);
            app_phy <= nphy_q;
        end
    end

    // R4
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(app_sel));

endmodule

// File: rtl/ircfg_status.sv
module ircfg_status
    import ircfg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en_q,
    input  enc_sel_t  app_sel,
    input  logic      live_entx,
    input  logic      live_enrx,
    input  logic      live_loop,
    output status_t   st,
    output logic [MODE_W-1:0] mode
);

    logic conflict, run_ok;
    ir_mode_e mode_e;

    always_comb begin
        conflict  = sel_conflict(app_sel);
        run_ok    = en_q && !conflict;
        st.err    = en_q && conflict;
        st.fir_on = run_ok && app_sel.fir;
        st.mir_on = run_ok && app_sel.mir;
        st.sir_on = run_ok && app_sel.sir;
        st.crc_on = run_ok && app_sel.crc16;
        st.tx_st  = live_entx;
        st.rx_st  = live_enrx && (!live_entx || live_loop);
        if (!run_ok)          mode_e = MODE_IDLE;
        else if (app_sel.sir) mode_e = MODE_SIR;
        else if (app_sel.mir) mode_e = MODE_MIR;
        else if (app_sel.fir) mode_e = MODE_FIR;
        else                  mode_e = MODE_IDLE;
        mode = mode_e;
    end

    // R6
    one_mode_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({st.fir_on, st.mir_on, st.sir_on}));

    // R5
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        st.err |-> (mode == MODE_W'(MODE_IDLE)) && !st.crc_on);

    // R9
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !en_q |-> ({st.err, st.fir_on, st.mir_on, st.sir_on, st.crc_on} == 5'b0));

endmodule

// File: rtl/ir_cfg_gate.sv
module ir_cfg_gate
    import ircfg_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    output logic [1:0]        mode_o,
    output logic              crc16_o,
    output logic [5:0]        baud_o,
    output logic [4:0]        pulse_w_o,
    output logic [4:0]        preamble_o,
    output logic              tx_on_o,
    output logic              rx_on_o
);

    logic [REG_W-1:0] cfg_q;
    phy_word_t        nphy_q;
    phy_word_t        app_phy;
    enc_sel_t         app_sel;
    status_t          st;
    logic             en_q;
    logic             commit;
    logic [MODE_W-1:0] mode;

    ircfg_stage #(.ADDR_W(ADDR_W)) stage_i (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .cfg_q  (cfg_q),
        .nphy_q (nphy_q),
        .en_q   (en_q),
        .commit (commit)
    );

    ircfg_commit commit_i (
        .clk     (clk),
        .rst     (rst),
        .commit  (commit),
        .cfg_q   (cfg_q),
        .nphy_q  (nphy_q),
        .app_sel (app_sel),
        .app_phy (app_phy)
    );

    ircfg_status status_i (
        .clk       (clk),
        .rst       (rst),
        .en_q      (en_q),
        .app_sel   (app_sel),
        .live_entx (cfg_q[CB_ENTX]),
        .live_enrx (cfg_q[CB_ENRX]),
        .live_loop (cfg_q[CB_LOOP]),
        .st        (st),
        .mode      (mode)
    );

    always_comb begin
        unique case (reg_addr)
            ADDR_W'(ADR_CFG):  reg_rdata = cfg_q;
            ADDR_W'(ADR_EN):   reg_rdata = status_word(en_q, st);
            ADDR_W'(ADR_NPHY): reg_rdata = nphy_q;
            ADDR_W'(ADR_APHY): reg_rdata = app_phy;
            default:           reg_rdata = '0;
        endcase
    end

    assign mode_o     = mode;
    assign crc16_o    = st.crc_on;
    assign baud_o     = app_phy.baud;
    assign pulse_w_o  = app_phy.pls;
    assign preamble_o = app_phy.pre;
    assign tx_on_o    = st.tx_st;
    assign rx_on_o    = st.rx_st;

    // R3
    phy_commit_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(en_q) |-> (app_phy == $past(nphy_q)));

    // R3
    phy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$rose(en_q) |-> $stable(app_phy));

    // R7
    rx_block_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_on_o && !cfg_q[CB_LOOP]) |-> !rx_on_o);

endmodule

// File: tb/ir_cfg_gate_tb_top.sv
module ir_cfg_gate_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic [1:0]  mode_o;
    logic        crc16_o;
    logic [5:0]  baud_o;
    logic [4:0]  pulse_w_o;
    logic [4:0]  preamble_o;
    logic        tx_on_o;
    logic        rx_on_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ir_cfg_gate dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mode_o(mode_o),
        .crc16_o(crc16_o), .baud_o(baud_o), .pulse_w_o(pulse_w_o),
        .preamble_o(preamble_o), .tx_on_o(tx_on_o), .rx_on_o(rx_on_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        reg_wr = 1'b0; reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // m = {crc,fir,mir,sir}; c = {loop,entx,enrx}
    function automatic logic [15:0] mk_cfg(input logic [3:0] m, input logic [2:0] c);
        logic [15:0] w;
        w = 16'h000B;
        w[7:4] = m;
        w[11] = c[0];
        w[12] = c[1];
        w[14] = c[2];
        return w;
    endfunction

    function automatic logic [15:0] exp_stat(input logic en, input logic [3:0] m, input logic [2:0] c);
        int cnt;
        logic err, ok;
        cnt = int'(m[0]) + int'(m[1]) + int'(m[2]);
        err = en && (cnt > 1);
        ok  = en && !err;
        return {en, err, ok & m[2], ok & m[1], ok & m[0], c[1],
                c[0] & (!c[1] | c[2]), ok & m[3], 8'h00};
    endfunction

    function automatic logic [1:0] exp_mode(input logic [3:0] m);
        int cnt;
        cnt = int'(m[0]) + int'(m[1]) + int'(m[2]);
        if (cnt != 1) return 2'd0;
        if (m[0]) return 2'd1;
        if (m[1]) return 2'd2;
        return 2'd3;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] v;
        logic [15:0] prev_phy;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check("R1 reset register", v, 16'h0000);
        end
        check("R1 reset mode", {14'd0, mode_o}, 16'd0);
        check("R1 reset outputs", {crc16_o, tx_on_o, rx_on_o, baud_o, pulse_w_o}, 16'd0);

        prev_phy = 16'h0000;
        for (int m = 0; m < 16; m++) begin
            for (int c = 0; c < 8; c++) begin
                logic [15:0] phy, cfg, cfg2, phy2;
                logic [3:0] m2;
                logic [2:0] c2;
                phy  = 16'((m * 4099 + c * 577 + 16'h1234) & 16'hFFFF);
                cfg  = mk_cfg(4'(m), 3'(c));
                m2   = ~4'(m);
                c2   = ~3'(c);
                cfg2 = mk_cfg(m2, c2);
                phy2 = ~phy;

                wr(2'd1, 16'h0000);
                rd(2'd1, v);
                check("R9 disable drops mode-on", v & 16'h7900, 16'h0000);
                check("R9 mode idle when disabled", {14'd0, mode_o}, 16'd0);
                rd(2'd3, v);
                check("R9 applied PHY kept", v, prev_phy);

                wr(2'd0, cfg);
                wr(2'd2, phy);
                rd(2'd0, v);
                check("R2 mode word readback", v, cfg);
                rd(2'd2, v);
                check("R2 next PHY readback", v, phy);
                rd(2'd3, v);
                check("R3 staged PHY not applied", v, prev_phy);

                wr(2'd1, 16'h8000);
                rd(2'd1, v);
                check("R5 R6 R7 status after commit", v, exp_stat(1'b1, 4'(m), 3'(c)));
                rd(2'd3, v);
                check("R3 PHY applied on enable edge", v, phy);
                check("R10 mode code", {14'd0, mode_o}, {14'd0, exp_mode(4'(m))});
                check("R10 fields", {baud_o, pulse_w_o, preamble_o}, phy);
                check("R10 crc16", {15'd0, crc16_o}, {15'd0, exp_stat(1'b1, 4'(m), 3'(c))[8]});

                // stage a different configuration while enabled
                wr(2'd0, cfg2);
                wr(2'd2, phy2);
                wr(2'd3, 16'hFFFF);
                rd(2'd1, v);
                check("R4 R7 staged selection ignored, live tx/rx",
                      v, exp_stat(1'b1, 4'(m), c2));
                check("R4 mode unchanged", {14'd0, mode_o}, {14'd0, exp_mode(4'(m))});
                rd(2'd3, v);
                check("R3 R2 PHY held while enabled", v, phy);

                // repeat enable with junk low byte
                wr(2'd1, 16'h80FF);
                rd(2'd1, v);
                check("R8 R4 re-enable no recommit", v, exp_stat(1'b1, 4'(m), c2));
                rd(2'd3, v);
                check("R3 re-enable keeps PHY", v, phy);
                prev_phy = phy;
            end
        end

        // R8 low byte reads zero while disabled too
        wr(2'd1, 16'h00FF);
        rd(2'd1, v);
        check("R8 low byte zero", v & 16'h80FF, 16'h0000);

        // R1 reset clears a live configuration
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd(2'd3, v);
        check("R1 reset clears applied PHY", v, 16'h0000);
        rd(2'd0, v);
        check("R1 reset clears mode word", v, 16'h0000);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule